// File: doc/BRIEF.md
# Selectable Asymmetric Glitch Filter

This block cleans up the receive side of an open-collector, wired-OR handshake backplane. Each bus line is active low. The block re-times each line through a two-flop synchronizer and inverts it, so an asserted (low) bus gives a high output. On a set of filtered channels the two edges are handled differently. An assertion reaches the output after a short fixed latency. A release only reaches the output once the bus has stayed released for a qualification window. If the bus is asserted again before the window runs out, the output stays high and the short release is discarded.

The window length comes from a 2-bit select that all filtered channels share. Each channel samples it only while its output is low. A further set of plain channels carries no filter: each passes both edges through with the same fixed latency. The system must set the select well ahead of the bus traffic it governs.

Top module: `asym_glitch_filter`

## Requirements
- R1: During and directly after a synchronous active-high reset, every filtered and plain output is low. The synchronizers reset to the released bus level (1).
- R2: Polarity is inverted. A bus line held low drives its output high, and a line held high drives it low.
- R3: A bus assertion (1 to 0) on a filtered channel raises its output exactly 3 clock cycles after the change, for every select code.
- R4: A bus release on a filtered channel lowers the output exactly W+2 cycles after the release, provided the bus stays released for at least W cycles, where W is the active window.
- R5: A release that lasts W-1 cycles or fewer, followed by a new assertion, leaves the output high for the whole pulse.
- R6: Select code 0 (binary 00) gives W=9, code 1 gives W=13, code 2 gives W=18 and code 3 gives W=31, each a parameter in clock cycles.
- R7: A channel captures the select only while its output is low. A change of select while the output is high does not alter the window of the release in progress. It takes effect from the next idle period.
- R8: The plain channels follow the inverted bus with 3 cycles of latency on both edges, and a one-cycle pulse passes through them.
- R9: Filtered channels run independently. A release pulse on one channel does not change the output of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_sel | input | 2 | Window select shared by the filtered channels |
| bus_filt_n | input | N_FILT | Active-low bus levels, filtered channels |
| bus_raw_n | input | N_RAW | Active-low bus levels, plain channels |
| filt_out | output | N_FILT | Filtered, inverted receive outputs |
| raw_out | output | N_RAW | Unfiltered, inverted receive outputs |

## Verification
Two events can land on the same clock edge: the window count reaching its end, and a new assertion of the bus. The test provokes this with release pulses of W-1, W and W+1 cycles for all four codes. A W-cycle pulse puts the re-assertion directly after the final counted cycle. A W-1 pulse makes the re-assertion clear the counter in the last cycle before the window would have closed. The test judges each case by whether the output dropped at all and, where it dropped, on exactly which cycle.

// File: rtl/agf_pkg.sv
package agf_pkg;

    typedef enum logic [1:0] {
        WIN_SHORT = 2'd0,
        WIN_MID_A = 2'd1,
        WIN_MID_B = 2'd2,
        WIN_LONG  = 2'd3
    } win_sel_e;

    localparam int unsigned SYNC_DEPTH = 2;

    function automatic int unsigned win_cycles(input win_sel_e s,
                                               input int unsigned w0,
                                               input int unsigned w1,
                                               input int unsigned w2,
                                               input int unsigned w3);
        case (s)
            WIN_SHORT: return w0;
            WIN_MID_A: return w1;
            WIN_MID_B: return w2;
            default:   return w3;
        endcase
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/agf_sync.sv
module agf_sync #(
    parameter int unsigned WIDTH   = 6,
    parameter logic        RST_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [agf_pkg::SYNC_DEPTH];

    genvar s;
    generate
        for (s = 0; s < agf_pkg::SYNC_DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage[s] <= {WIDTH{RST_LVL}};
                else if (s == 0)
                    stage[s] <= d;
                else
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage[agf_pkg::SYNC_DEPTH-1];
endmodule

// File: rtl/agf_channel.sv
module agf_channel #(
    parameter int unsigned W0 = 9,
    parameter int unsigned W1 = 13,
    parameter int unsigned W2 = 18,
    parameter int unsigned W3 = 31,
    parameter int unsigned CW = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       asserted,
    input  logic [1:0] sel,
    output logic       filt_q
);
    import agf_pkg::*;

    logic          out_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] sel_len;
    logic          last_cnt;

    assign sel_len  = CW'(win_cycles(win_sel_e'(sel), W0, W1, W2, W3));
    assign last_cnt = (cnt_q == len_q - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            cnt_q <= '0;
            len_q <= CW'(W0);
        end else if (!out_q) begin
            // idle: track the select, wait for an assertion
            len_q <= sel_len;
            cnt_q <= '0;
            if (asserted) out_q <= 1'b1;
        end else if (asserted) begin
            cnt_q <= '0;
        end else if (last_cnt) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign filt_q = out_q;

    // R3: an assertion seen while idle raises the output on the next edge
    a_r3_rise_fast: assert property (@(posedge clk) disable iff (rst)
        (!out_q && asserted) |=> out_q);

    // R5: an asserted input never lets a high output drop
    a_r5_hold_high: assert property (@(posedge clk) disable iff (rst)
        (out_q && asserted) |=> out_q);

    // R7: the window is frozen while the output is high
    a_r7_len_frozen: assert property (@(posedge clk) disable iff (rst)
        out_q |=> $stable(len_q));

    // R4: the count never passes the window
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < len_q);

    // R4: a fall only follows a completed window
    a_r4_fall_full: assert property (@(posedge clk) disable iff (rst)
        $fell(out_q) |-> ($past(cnt_q) == $past(len_q) - CW'(1)));
endmodule

// File: rtl/asym_glitch_filter.sv
module asym_glitch_filter #(
    parameter int unsigned N_FILT = 3,
    parameter int unsigned N_RAW  = 3,
    parameter int unsigned WIN0   = 9,
    parameter int unsigned WIN1   = 13,
    parameter int unsigned WIN2   = 18,
    parameter int unsigned WIN3   = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        win_sel,
    input  logic [N_FILT-1:0] bus_filt_n,
    input  logic [N_RAW-1:0]  bus_raw_n,
    output logic [N_FILT-1:0] filt_out,
    output logic [N_RAW-1:0]  raw_out
);
    localparam int unsigned NALL    = N_FILT + N_RAW;
    localparam int unsigned WIN_MAX = agf_pkg::max4(WIN0, WIN1, WIN2, WIN3);
    localparam int unsigned CW      = $clog2(WIN_MAX + 1);

    logic [NALL-1:0] bus_sync;

    agf_sync #(.WIDTH(NALL), .RST_LVL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_raw_n, bus_filt_n}),
        .q   (bus_sync)
    );

    genvar i;
    generate
        for (i = 0; i < N_FILT; i++) begin : g_filt
            agf_channel #(.W0(WIN0), .W1(WIN1), .W2(WIN2), .W3(WIN3), .CW(CW)) u_ch (
                .clk      (clk),
                .rst      (rst),
                .asserted (~bus_sync[i]),
                .sel      (win_sel),
                .filt_q   (filt_out[i])
            );
        end
        for (i = 0; i < N_RAW; i++) begin : g_raw
            always_ff @(posedge clk) begin
                if (rst) raw_out[i] <= 1'b0;
                else     raw_out[i] <= ~bus_sync[N_FILT + i];
            end
        end
    endgenerate

    // R1: outputs are low directly after a reset cycle
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (filt_out == '0 && raw_out == '0));
endmodule

// File: tb/asym_glitch_filter_tb_top.sv
module asym_glitch_filter_tb_top;
    localparam int NF = 3;
    localparam int NR = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    win_sel = 2'd0;
    logic [NF-1:0] bus_filt_n = '1;
    logic [NR-1:0] bus_raw_n  = '1;
    logic [NF-1:0] filt_out;
    logic [NR-1:0] raw_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    asym_glitch_filter dut_i (
        .clk(clk), .rst(rst), .win_sel(win_sel),
        .bus_filt_n(bus_filt_n), .bus_raw_n(bus_raw_n),
        .filt_out(filt_out), .raw_out(raw_out)
    );

    function automatic int win_of(input int code);
        case (code)
            0: return 9;
            1: return 13;
            2: return 18;
            default: return 31;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1;
        cyc(3);
        chk("R1 filt_out in reset", int'(filt_out), 0);
        chk("R1 raw_out in reset", int'(raw_out), 0);
        rst = 1'b0;
        cyc(4);
        chk("R1 filt_out after reset", int'(filt_out), 0);
        chk("R1 raw_out after reset", int'(raw_out), 0);
    endtask

    // R2, R3: assertion latency on all filtered channels
    task automatic t_assert(input int code);
        int rise;
        win_sel = 2'(code);
        bus_filt_n = '1;
        cyc(40);
        bus_filt_n = '0;
        rise = -1;
        for (int i = 1; i <= 6; i++) begin
            cyc(1);
            if (filt_out == '1 && rise < 0) rise = i;
        end
        chk($sformatf("R3 rise latency code %0d", code), rise, 3);
        chk("R2 asserted bus gives high output", int'(filt_out), 7);
    endtask

    // R4, R5, R6, R9: release pulse of length len on channel 0
    task automatic t_pulse(input int code, input int len);
        int w, fall;
        w = win_of(code);
        t_assert(code);
        bus_filt_n[0] = 1'b1;
        fall = -1;
        for (int i = 1; i <= len + w + 6; i++) begin
            cyc(1);
            if (!filt_out[0] && fall < 0) fall = i;
            if (filt_out[2:1] != 2'b11)
                chk("R9 idle channels stay high", int'(filt_out[2:1]), 3);
            if (i == len) bus_filt_n[0] = 1'b0;
        end
        if (len >= w)
            chk($sformatf("R4/R6 fall cycle code %0d len %0d", code, len), fall, w + 2);
        else
            chk($sformatf("R5 reject code %0d len %0d", code, len), fall, -1);
        bus_filt_n = '1;
        cyc(w + 6);
        chk("R2 released bus gives low output", int'(filt_out), 0);
    endtask

    // R7: select change while high takes effect later
    task automatic t_sel_change();
        int fall;
        t_assert(0);
        win_sel = 2'd3;
        cyc(2);
        bus_filt_n = '1;
        fall = -1;
        for (int i = 1; i <= 40; i++) begin
            cyc(1);
            if (!filt_out[0] && fall < 0) fall = i;
            if (i == 10) bus_filt_n = '0;
        end
        chk("R7 old window used after change", fall, 11);
        bus_filt_n = '0;
        cyc(6);
        bus_filt_n = '1;
        fall = -1;
        for (int i = 1; i <= 40; i++) begin
            cyc(1);
            if (!filt_out[0] && fall < 0) fall = i;
            if (i == 10) bus_filt_n = '0;
        end
        chk("R7 new window applied after idle", fall, -1);
        bus_filt_n = '1;
        cyc(40);
    endtask

    // R8: plain channels
    task automatic t_raw();
        int rise, fall, seen;
        bus_raw_n = '1;
        cyc(5);
        bus_raw_n = 3'b010;
        rise = -1;
        for (int i = 1; i <= 5; i++) begin
            cyc(1);
            if (raw_out == 3'b101 && rise < 0) rise = i;
        end
        chk("R8 raw rise latency", rise, 3);
        bus_raw_n = '1;
        fall = -1;
        for (int i = 1; i <= 5; i++) begin
            cyc(1);
            if (raw_out == '0 && fall < 0) fall = i;
        end
        chk("R8 raw fall latency", fall, 3);
        bus_raw_n = 3'b110;
        cyc(1);
        bus_raw_n = '1;
        seen = 0;
        for (int i = 1; i <= 5; i++) begin
            cyc(1);
            if (raw_out[0]) seen++;
        end
        chk("R8 one-cycle pulse passes", seen, 1);
    endtask

    initial begin
        cyc(1);
        t_reset();
        for (int c = 0; c < 4; c++) begin
            t_pulse(c, win_of(c) - 1);
            t_pulse(c, win_of(c));
            t_pulse(c, win_of(c) + 1);
        end
        t_pulse(3, 2);
        t_sel_change();
        t_raw();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule